// File: doc/BRIEF.md
# Keyed-sequence watchdog timer

This block is a recovery watchdog for an 8-bit controller. It listens on a plain special-function-register write bus (address, data, write strobe) and does nothing until software writes the key pair 0x1E then 0xE1 to one fixed address. From then on it counts machine-cycle enable pulses through a selectable power-of-two prescaler into a 14-bit counter. If software does not repeat the same key pair in time, the counter overflows and the block raises an active-high reset output for a fixed number of clock periods.

Once armed, no software write can stop it. Only the external hardware reset or its own overflow reset returns it to the idle state. The key register is write-only, and the count cannot be read or loaded from the bus. The output pulse is meant to drive the device reset, so the block treats itself as reset while the pulse is high.

Top module: `kwdt_top`

## Requirements
- R1: After reset the block is disarmed and `wdt_rst_o` is 0. It stays 0 for any length of time until a full key sequence completes.
- R2: A write of 0x1E followed by a write of 0xE1, both to address 0xA6, arms the block. With prescaler select `psel`, `wdt_rst_o` first goes high after the clock edge that carries the (16383 × 2^psel)-th counted `mc_en` pulse following the arming write.
- R3: Only cycles with `mc_en` high count toward the timeout. `psel` (0..7) divides the `mc_en` rate by 2^psel before the 14-bit counter.
- R4: Repeating the 0x1E, 0xE1 sequence at 0xA6 while armed clears the prescaler and the counter, so the full timeout restarts from that write.
- R5: After a 0x1E write to 0xA6, a write to 0xA6 of any value other than 0xE1 (0x1E included) drops the sequence without action. A lone 0xE1 write does nothing.
- R6: Writes to any address other than 0xA6 leave the key-sequence progress unchanged. A key pair split by such a write still completes.
- R7: No bus write can disarm an armed watchdog. Broken or partial sequences leave the running timeout unchanged.
- R8: On overflow `wdt_rst_o` is high for exactly 96 consecutive clock periods.
- R9: Overflow disarms the block. While `wdt_rst_o` is high, bus writes are ignored. After the pulse the block stays idle until it is armed again.
- R10: The asynchronous active-low `rst_n` disarms the block, clears the timeout and forces `wdt_rst_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mc_en | input | 1 | Machine-cycle enable, one pulse per counted cycle |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| psel | input | 3 | Prescaler select, divide by 2^psel |
| wdt_rst_o | output | 1 | Active-high reset pulse raised on overflow |

## Verification
The embedded assertions check every cycle that:
- a write to a foreign address never moves the key state;
- a disarmed counter sits at zero;
- the counter steps by one on each prescaler tick;
- a completed key sequence leaves the block armed with a cleared count;
- the armed flag falls only on overflow;
- the output pulse starts on overflow and counts down by one per clock.

Only the bench scenarios can show the end-to-end behaviour:
- the exact overflow edge relative to the arming or servicing write, for two prescaler settings with a gapped `mc_en`;
- the exact pulse width;
- that broken sequences neither arm nor service the watchdog;
- that nothing fires after an overflow or a hardware reset until the block is armed again.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  typedef enum logic {
    KEY_WAIT,
    KEY_HALF
  } key_state_e;

  // Mask for a divide-by-2^sel prescaler: terminal count of the prescale counter.
  function automatic int unsigned div_mask(input int unsigned sel);
    return (32'd1 << sel) - 32'd1;
  endfunction

  // Counter value at which the watchdog overflows.
  function automatic int unsigned cnt_limit(input int unsigned width);
    return (32'd1 << width) - 32'd1;
  endfunction

endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              key_done
);
  import kwdt_pkg::*;

  key_state_e st;
  logic       hit;

  assign hit      = we && (addr == KEY_ADDR);
  assign key_done = !hold && hit && (st == KEY_HALF) && (wdata == KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= KEY_WAIT;
    end else if (hold) begin
      st <= KEY_WAIT;
    end else if (hit) begin
      case (st)
        KEY_WAIT: st <= (wdata == KEY_FIRST) ? KEY_HALF : KEY_WAIT;
        default:  st <= KEY_WAIT;
      endcase
    end
  end

  // R6: a write elsewhere (or no write) leaves the key progress alone
  assert_foreign_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !hold) |=> (st == $past(st)));

  // R9: during the reset pulse the sequence is held idle
  assert_hold_clears_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (st == KEY_WAIT));

  // R5: a completed or broken second write always returns to idle
  assert_second_write_idles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && st == KEY_HALF) |=> (st == KEY_WAIT));

endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             mc_en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;

  assign mask = PRE_W'(kwdt_pkg::div_mask(32'(sel)));
  assign tick = run && mc_en && (pre == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
    end else if (clr) begin
      pre <= '0;
    end else if (run && mc_en) begin
      pre <= tick ? '0 : pre + 1'b1;
    end
  end

  // R3: cycles without a machine-cycle enable do not advance the prescaler
  assert_idle_cycle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_en && !clr) |=> (pre == $past(pre)));

  // R4: a completed key sequence restarts the prescaler
  assert_clear_prescale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre == '0));

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_done,
  input  logic tick,
  output logic armed,
  output logic ovf
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(kwdt_pkg::cnt_limit(CNT_W) - 1);

  logic [CNT_W-1:0] cnt;

  assign ovf = armed && tick && !key_done && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (key_done) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (ovf) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (armed && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1: a disarmed watchdog holds a zero count
  assert_no_count_disarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !key_done) |=> (cnt == '0));

  // R2: each prescaler tick advances the armed counter by one
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tick && !ovf && !key_done) |=> (cnt == $past(cnt) + 1'b1));

  // R4: a completed key sequence arms and clears
  assert_service_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    key_done |=> (armed && cnt == '0));

  // R7: the armed flag falls only through overflow
  assert_stay_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ovf) |=> armed);

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int PULSE_LEN = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  output logic busy
);
  localparam int P_W = $clog2(PULSE_LEN + 1);

  logic [P_W-1:0] pcnt;

  assign busy = (pcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (ovf) begin
      pcnt <= P_W'(PULSE_LEN);
    end else if (busy) begin
      pcnt <= pcnt - 1'b1;
    end
  end

  // R8: overflow starts a full-length pulse
  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (busy && pcnt == P_W'(PULSE_LEN)));

  // R8: the pulse shortens by one clock at a time
  assert_pulse_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ovf) |=> (pcnt == $past(pcnt) - 1'b1));

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 14,
  parameter int SEL_W     = 3,
  parameter int PULSE_LEN = 96,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_en,
  input  logic              sfr_we,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic [SEL_W-1:0]  psel,
  output logic              wdt_rst_o
);
  logic key_done;
  logic tick;
  logic armed;
  logic ovf;
  logic busy;

  kwdt_keyseq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_key (
    .clk(clk), .rst_n(rst_n), .hold(busy), .we(sfr_we),
    .addr(sfr_addr), .wdata(sfr_wdata), .key_done(key_done)
  );

  kwdt_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(key_done), .run(armed),
    .mc_en(mc_en), .sel(psel), .tick(tick)
  );

  kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .key_done(key_done), .tick(tick),
    .armed(armed), .ovf(ovf)
  );

  kwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .ovf(ovf), .busy(busy)
  );

  assign wdt_rst_o = busy;

  // R9: while the reset pulse is out the watchdog is disarmed
  assert_pulse_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !armed);

  // R9: no key sequence can complete during the pulse
  assert_no_key_in_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !key_done);

  // R10: hardware reset forces the output low
  always_comb begin
    if (!rst_n) assert_reset_low_R10: assert (!wdt_rst_o);
  end

endmodule

// File: tb/kwdt_top_test.sv
module kwdt_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 16383;
  localparam int PULSE      = 96;
  localparam int WDOG       = 190000;

  // vector: addr1 data1 addr2 data2 addr3 data3, then index (1..3) of the write
  // that completes a service, 0 when none should
  localparam int NV = 5;
  localparam logic [49:0] VEC [NV] = '{
    {8'hA6, 8'h1E, 8'hA6, 8'hE1, 8'h80, 8'h00, 2'd2},
    {8'hA6, 8'h1E, 8'h90, 8'hE1, 8'hA6, 8'hE1, 2'd3},
    {8'hA6, 8'h1E, 8'hA6, 8'h55, 8'hA6, 8'hE1, 2'd0},
    {8'hA6, 8'h1E, 8'hA6, 8'h1E, 8'hA6, 8'hE1, 2'd0},
    {8'hA7, 8'h1E, 8'hA6, 8'hE1, 8'h80, 8'h00, 2'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_en = 1'b1;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic [2:0] psel = '0;
  logic       wdt_rst_o;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  gap_mode = 1'b0;
  bit  done = 1'b0;

  kwdt_top uut (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .sfr_we(sfr_we),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .psel(psel),
    .wdt_rst_o(wdt_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  // gapped enable: pulse absent on edges e with (e-1)%4 == 3
  always @(negedge clk) mc_en <= gap_mode ? ((cyc % 4) != 3) : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d, output int edge_no);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sfr_we = 1'b0;
    edge_no = cyc;
  endtask

  task automatic wait_rise(input int limit, output bit found, output int rise_edge, output int width);
    found = 1'b0; rise_edge = -1; width = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (wdt_rst_o) begin
        found = 1'b1; rise_edge = cyc; break;
      end
    end
    if (found) begin
      width = 1;
      for (int k = 0; k < 4 * PULSE; k++) begin
        @(negedge clk);
        if (wdt_rst_o) width++;
        else break;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
    finish_run();
  end

  initial begin
    int  e_arm, e_w, e_svc, rise, wid, exp_edge, cntp;
    bit  found;
    logic [49:0] v;

    repeat (3) @(negedge clk);
    check(wdt_rst_o == 1'b0, "R10 output low in reset", wdt_rst_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wdt_rst_o == 1'b0, "R1 output low after reset", wdt_rst_o, 0);

    // table walk: arm, idle, apply three writes, time the overflow
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      sfr_write(8'hA6, 8'h1E, e_w);
      sfr_write(8'hA6, 8'hE1, e_arm);
      repeat (20) @(negedge clk);
      e_svc = e_arm;
      sfr_write(v[49:42], v[41:34], e_w); if (v[1:0] == 2'd1) e_svc = e_w;
      sfr_write(v[33:26], v[25:18], e_w); if (v[1:0] == 2'd2) e_svc = e_w;
      sfr_write(v[17:10], v[9:2],   e_w); if (v[1:0] == 2'd3) e_svc = e_w;
      exp_edge = e_svc + BASE;
      wait_rise(BASE + 200, found, rise, wid);
      // R2 R4 R5 R6 R7: overflow edge set by the last valid arming/servicing write
      check(found && rise == exp_edge, $sformatf("R4/R5/R6/R7 vector %0d overflow edge", i), rise, exp_edge);
      check(wid == PULSE, $sformatf("R8 vector %0d pulse width", i), wid, PULSE);
    end

    // R9: after overflow, stays idle; lone second key does nothing
    sfr_write(8'hA6, 8'hE1, e_w);
    wait_rise(BASE + 600, found, rise, wid);
    check(!found, "R9 no pulse after overflow without re-arming", rise, -1);

    // R10: hardware reset disarms a running watchdog
    sfr_write(8'hA6, 8'h1E, e_w);
    sfr_write(8'hA6, 8'hE1, e_arm);
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(wdt_rst_o == 1'b0, "R10 output low during reset", wdt_rst_o, 0);
    rst_n = 1'b1;
    // R5 R6 R1: broken sequences must not arm
    sfr_write(8'hA6, 8'hE1, e_w);
    sfr_write(8'hA6, 8'h1E, e_w);
    sfr_write(8'hA6, 8'h55, e_w);
    sfr_write(8'hA6, 8'hE1, e_w);
    sfr_write(8'hA7, 8'h1E, e_w);
    sfr_write(8'hA6, 8'hE1, e_w);
    wait_rise(BASE + 600, found, rise, wid);
    check(!found, "R1/R5/R10 no pulse after reset and broken sequences", rise, -1);

    // R3: psel=1 with a gapped machine-cycle enable
    psel = 3'd1;
    gap_mode = 1'b1;
    repeat (4) @(negedge clk);
    sfr_write(8'hA6, 8'h1E, e_w);
    sfr_write(8'hA6, 8'hE1, e_arm);
    cntp = 0;
    exp_edge = e_arm;
    while (cntp < 2 * BASE) begin
      exp_edge++;
      if (((exp_edge - 1) % 4) != 3) cntp++;
    end
    wait_rise(3 * BASE, found, rise, wid);
    check(found && rise == exp_edge, "R2/R3 prescaled gapped overflow edge", rise, exp_edge);
    check(wid == PULSE, "R8 prescaled pulse width", wid, PULSE);

    finish_run();
  end

endmodule